// File: doc/BRIEF.md
# Li-ion charge cycle controller

This block sequences a single-cell lithium-ion charge cycle from clean comparator decisions. It watches the battery voltage thresholds, the charge-current level, the enable and high-impedance controls, input power and the thermistor zone, and from them decides the charge phase. It also decides whether the battery switch is closed, whether the current or regulation voltage must be reduced, whether the converter must be held off, and whether the open-drain style status flag is pulled low. The analog loops and the comparators sit outside it. So does the battery-presence sequencer, which it asks for through a request and acknowledge pair once the cycle terminates.

The controller moves a cycle through five phases: conditioning, fast charge, constant-voltage taper, presence detection and done. Every qualifying condition must hold for a fixed number of clock cycles before it acts, and that number is a parameter. A safety timer guards each cycle. It counts prescaled ticks, runs at half speed while any current-limiting loop is active and restarts on thermal shutdown. If it expires, the cycle ends in a latched fault, and only an enable toggle, a high-impedance toggle or an input power cycle clears that fault.

Top module: `chg_cycle_ctrl`

## Requirements
- R1: While reset is held, `phase` is 0 (idle), `chg_stat_n` is 1 and `bat_sw_en` is 0.
- R2: The block is ready to charge when `in_good`=1, `chg_en_n`=0 and `hiz_req`=0. In that state, a rise of `in_good`, any edge of `chg_en_n` or any edge of `hiz_req` starts a cycle. A start sets `phase` to 1 (conditioning), drives `chg_stat_n` to 0 and closes the battery switch. When the block stops being ready to charge, `phase` returns to 0 and `chg_stat_n` goes to 1.
- R3: Conditioning moves to fast charge (`phase`=2) only after `bat_ok_short` has been 1 for HOLD_CYC consecutive cycles. Any gap in that condition restarts the count.
- R4: Fast charge moves to taper (`phase`=3) on `cv_loop`=1. Taper moves to detection (`phase`=4) only after `ichg_low`=1 together with `bat_low_rch`=0 has lasted HOLD_CYC cycles. In detection, `det_req`=1, `bat_sw_en`=0 and `chg_stat_n`=1.
- R5: Detection moves to done (`phase`=5) on `det_found`=1. Done returns to conditioning after `bat_low_rch` has been 1 for HOLD_CYC cycles. That recharge cycle leaves `chg_stat_n` at 1.
- R6: The safety timer clears at every cycle start and counts only in phases 1 to 3. At full rate it expires after TIMER_TICKS ticks of TICK_DIV cycles each. Expiry sets `phase` to 6 (fault), opens the battery switch and drives `chg_stat_n` to 1.
- R7: While any bit of `limit_loops` is 1, the safety timer advances at half rate.
- R8: A cycle with `therm_sd`=1 clears the elapsed safety time.
- R9: The fault phase is left only through a start event (R2) or through a loss of the ready condition. A recharge condition has no effect on it.
- R10: `ts_zone` encodings are 0 normal, 1 cool, 2 warm and 3 hot or cold. Zone 3 freezes the phase and the timer and opens the switch. Zone 2 sets `vreg_low` and zone 1 sets `i_half`. Both outputs apply only in phases 1 to 3.
- R11: `bat_over_reg`=1 sets `conv_off` and opens the battery switch one cycle later. Both return to normal one cycle after it clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_good | input | 1 | Input supply inside its valid window |
| chg_en_n | input | 1 | Charge enable, active low |
| hiz_req | input | 1 | High-impedance mode request |
| bat_ok_short | input | 1 | Battery above the short threshold (hysteresis outside) |
| cv_loop | input | 1 | Voltage regulation loop in control |
| ichg_low | input | 1 | Charge current below the termination level |
| bat_low_rch | input | 1 | Battery below the recharge threshold |
| bat_over_reg | input | 1 | Battery above the regulation voltage |
| limit_loops | input | 3 | System-load, input-voltage and die-thermal loops reducing current |
| therm_sd | input | 1 | Die thermal shutdown |
| ts_zone | input | 2 | Thermistor zone code |
| det_found | input | 1 | Presence sequencer reports a battery |
| phase | output | 3 | Charge phase code |
| det_req | output | 1 | Request to the presence sequencer |
| bat_sw_en | output | 1 | Battery switch closed |
| i_half | output | 1 | Halve the charge current |
| vreg_low | output | 1 | Select the lowered regulation voltage |
| conv_off | output | 1 | Hold the converter off |
| chg_stat_n | output | 1 | Status flag, 0 while a cycle is reported |

## Verification
The assertions check several rules on every cycle. A qualifier can never report a hold unless its condition was present in the previous cycle. The timer never ticks on two cycles in a row at half rate. A latched fault persists until a start event or a loss of readiness. The status stays released in detection, done, fault and a recharge entry, and the phase stays frozen in the hot or cold zone. Detection is entered only from taper, and an over-voltage battery turns the converter off on the next cycle. Only the bench scenarios show the exact hold lengths, the expiry times at full and half rate, the timer restart on thermal shutdown and the release of a fault through the toggle inputs.

// File: rtl/chg_cycle_pkg.sv
// Shared encodings for the charge cycle controller.
// Assumes: phase codes are visible at the block boundary and must not change.
package chg_cycle_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_COND   = 3'd1,
        PH_FAST   = 3'd2,
        PH_TAPER  = 3'd3,
        PH_DETECT = 3'd4,
        PH_DONE   = 3'd5,
        PH_FAULT  = 3'd6
    } chg_phase_e;

    typedef enum logic [1:0] {
        TZ_NORMAL  = 2'd0,
        TZ_COOL    = 2'd1,
        TZ_WARM    = 2'd2,
        TZ_EXTREME = 2'd3
    } tzone_e;

    localparam int N_LIMIT_LOOPS = 3;
    localparam int N_QUALIFIERS  = 3;
    localparam int N_EDGE_INPUTS = 3;

endpackage

// File: rtl/chg_toggle_det.sv
// Edge detector bank: one register per channel and a rise and toggle flag for each.
// Assumes: inputs are already synchronous and free of glitches.
// RST_LVL sets the assumed previous level after reset.
module chg_toggle_det #(
    parameter int N = 3,
    parameter logic [N-1:0] RST_LVL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] tog
);

    for (genvar gi = 0; gi < N; gi++) begin : g_ch
        logic prev_q;

        // Hold the previous level of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= RST_LVL[gi];
            else        prev_q <= lvl[gi];
        end

        assign rise[gi] = lvl[gi] & ~prev_q;
        assign tog[gi]  = lvl[gi] ^ prev_q;
    end

endmodule

// File: rtl/chg_hold_qual.sv
// Hold qualifier: held goes high once cond has been true for HOLD_CYC
// consecutive cycles and stays high while cond remains true.
// Assumes: HOLD_CYC >= 1; any low cycle restarts the count.
module chg_hold_qual #(
    parameter int HOLD_CYC = 1049
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic held
);

    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] cnt_q;

    // Count consecutive true cycles, saturating at the hold length.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (!cond)                 cnt_q <= '0;
        else if (cnt_q != CW'(HOLD_CYC)) cnt_q <= cnt_q + 1'b1;
    end

    assign held = (cnt_q == CW'(HOLD_CYC));

    assert_held_needs_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> $past(cond));

endmodule

// File: rtl/chg_safety_timer.sv
// Safety timer: a prescaler feeds a saturating tick counter, and expired
// latches once TIMER_TICKS ticks have passed.
// Assumes: clr has priority. While run is high, the prescaler gains 2 per cycle,
// or 1 per cycle when half is high, and a tick occurs every 2*TICK_DIV units.
module chg_safety_timer #(
    parameter int TICK_DIV    = 32768,
    parameter int TIMER_TICKS = 21600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic half,
    output logic expired
);

    localparam int FULL = 2 * TICK_DIV;
    localparam int PW   = $clog2(FULL + 2) + 1;
    localparam int CW   = $clog2(TIMER_TICKS + 1);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] pre_sum;
    logic [CW-1:0] cnt_q;
    logic          tick;

    // Next prescaler value and tick decision.
    always_comb begin
        pre_sum = pre_q + (half ? PW'(1) : PW'(2));
        tick    = run && !expired && (pre_sum >= PW'(FULL));
    end

    // Prescaler accumulates rate units between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        pre_q <= '0;
        else if (run && !expired) pre_q <= tick ? (pre_sum - PW'(FULL)) : pre_sum;
    end

    // Tick counter runs up to the expiry count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (tick)     cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == CW'(TIMER_TICKS));

    assert_expiry_while_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(run));

    assert_clear_drops_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !expired);

    assert_half_rate_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && half && !clr && $past(run && half && !clr)) |-> !(tick && $past(tick)));

endmodule

// File: rtl/chg_cycle_ctrl.sv
// Charge cycle controller top: phase state machine, status flag, thermistor
// zone gating, over-voltage hold-off, safety timer and hold qualifiers.
// Assumes: every input is synchronous to clk and free of glitches. Threshold
// hysteresis is applied outside. HOLD_CYC sets the cycles per qualification.
module chg_cycle_ctrl
    import chg_cycle_pkg::*;
#(
    parameter int HOLD_CYC    = 1049,
    parameter int TICK_DIV    = 32768,
    parameter int TIMER_TICKS = 21600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_good,
    input  logic       chg_en_n,
    input  logic       hiz_req,
    input  logic       bat_ok_short,
    input  logic       cv_loop,
    input  logic       ichg_low,
    input  logic       bat_low_rch,
    input  logic       bat_over_reg,
    input  logic [2:0] limit_loops,
    input  logic       therm_sd,
    input  logic [1:0] ts_zone,
    input  logic       det_found,
    output logic [2:0] phase,
    output logic       det_req,
    output logic       bat_sw_en,
    output logic       i_half,
    output logic       vreg_low,
    output logic       conv_off,
    output logic       chg_stat_n
);

    localparam int Q_SHORT = 0;
    localparam int Q_TERM  = 1;
    localparam int Q_RCH   = 2;

    chg_phase_e phase_q, phase_d;
    logic       stat_q, stat_d;
    logic       conv_off_q;

    logic [N_EDGE_INPUTS-1:0] edge_lvl, edge_rise, edge_tog;
    logic [N_QUALIFIERS-1:0]  q_cond, q_held;

    logic active, start_evt, rch_start, charging, susp;
    logic tmr_clr, tmr_run, tmr_half, tmr_exp;

    // Edge detection on power, enable and high-impedance controls.
    assign edge_lvl = {hiz_req, chg_en_n, in_good};

    chg_toggle_det #(
        .N       (N_EDGE_INPUTS),
        .RST_LVL (3'b010)
    ) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (edge_lvl),
        .rise (edge_rise),
        .tog  (edge_tog)
    );

    // Readiness and start event decode.
    always_comb begin
        active    = in_good && !chg_en_n && !hiz_req;
        start_evt = active && (edge_rise[0] || edge_tog[1] || edge_tog[2]);
        charging  = (phase_q == PH_COND) || (phase_q == PH_FAST) || (phase_q == PH_TAPER);
        susp      = (tzone_e'(ts_zone) == TZ_EXTREME);
    end

    // Conditions that must persist for the hold length, gated by phase.
    always_comb begin
        q_cond[Q_SHORT] = bat_ok_short && (phase_q == PH_COND);
        q_cond[Q_TERM]  = ichg_low && !bat_low_rch && (phase_q == PH_TAPER);
        q_cond[Q_RCH]   = bat_low_rch && (phase_q == PH_DONE);
    end

    for (genvar gq = 0; gq < N_QUALIFIERS; gq++) begin : g_qual
        chg_hold_qual #(
            .HOLD_CYC(HOLD_CYC)
        ) u_qual (
            .clk  (clk),
            .rst_n(rst_n),
            .cond (q_cond[gq]),
            .held (q_held[gq])
        );
    end

    assign rch_start = active && (phase_q == PH_DONE) && q_held[Q_RCH];

    // Safety timer control: clear on starts, thermal shutdown and outside charging.
    always_comb begin
        tmr_clr  = start_evt || rch_start || therm_sd || !charging;
        tmr_run  = charging && !susp;
        tmr_half = |limit_loops;
    end

    chg_safety_timer #(
        .TICK_DIV   (TICK_DIV),
        .TIMER_TICKS(TIMER_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .run    (tmr_run),
        .half   (tmr_half),
        .expired(tmr_exp)
    );

    // Next phase and status decision.
    always_comb begin
        phase_d = phase_q;
        stat_d  = stat_q;
        if (!active) begin
            phase_d = PH_IDLE;
            stat_d  = 1'b0;
        end else if (start_evt) begin
            phase_d = PH_COND;
            stat_d  = 1'b1;
        end else begin
            case (phase_q)
                PH_COND, PH_FAST, PH_TAPER: begin
                    if (tmr_exp) begin
                        phase_d = PH_FAULT;
                        stat_d  = 1'b0;
                    end else if (!susp) begin
                        if (phase_q == PH_COND && q_held[Q_SHORT]) begin
                            phase_d = PH_FAST;
                        end else if (phase_q == PH_FAST && cv_loop) begin
                            phase_d = PH_TAPER;
                        end else if (phase_q == PH_TAPER && q_held[Q_TERM]) begin
                            phase_d = PH_DETECT;
                            stat_d  = 1'b0;
                        end
                    end
                end
                PH_DETECT: if (det_found) phase_d = PH_DONE;
                PH_DONE:   if (q_held[Q_RCH]) phase_d = PH_COND;
                default:   phase_d = phase_q;
            endcase
        end
    end

    // Phase and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            stat_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            stat_q  <= stat_d;
        end
    end

    // Converter hold-off follows battery over-voltage one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) conv_off_q <= 1'b0;
        else        conv_off_q <= bat_over_reg;
    end

    // Output decode.
    always_comb begin
        phase      = phase_q;
        det_req    = (phase_q == PH_DETECT);
        bat_sw_en  = charging && !susp && !conv_off_q;
        i_half     = charging && (tzone_e'(ts_zone) == TZ_COOL);
        vreg_low   = charging && (tzone_e'(ts_zone) == TZ_WARM);
        conv_off   = conv_off_q;
        chg_stat_n = !stat_q;
    end

    assert_phase_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q != 3'd7);

    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_FAULT && active && !start_evt) |=> (phase_q == PH_FAULT));

    assert_stat_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DETECT || phase_q == PH_DONE || phase_q == PH_FAULT) |-> chg_stat_n);

    assert_recharge_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_COND && $past(phase_q) == PH_DONE) |-> chg_stat_n);

    assert_detect_from_taper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DETECT && $past(phase_q) != PH_DETECT) |-> ($past(phase_q) == PH_TAPER));

    assert_suspend_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (susp && charging && active && !start_evt && !tmr_exp) |=> $stable(phase_q));

    assert_ovp_conv_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bat_over_reg |=> (conv_off && !bat_sw_en));

endmodule

// File: tb/chg_cycle_ctrl_bench.sv
// Bench: table of stimulus rows and expected outputs, then directed corner tests.
module chg_cycle_ctrl_bench;

    localparam int HOLD = 8;
    localparam int TDIV = 4;
    localparam int TTKS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_good = 1'b1, chg_en_n = 1'b0, hiz_req = 1'b0;
    logic       bat_ok_short = 1'b0, cv_loop = 1'b0, ichg_low = 1'b0;
    logic       bat_low_rch = 1'b0, bat_over_reg = 1'b0, therm_sd = 1'b0, det_found = 1'b0;
    logic [2:0] limit_loops = 3'b000;
    logic [1:0] ts_zone = 2'd0;
    logic [2:0] phase;
    logic       det_req, bat_sw_en, i_half, vreg_low, conv_off, chg_stat_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    chg_cycle_ctrl #(
        .HOLD_CYC   (HOLD),
        .TICK_DIV   (TDIV),
        .TIMER_TICKS(TTKS)
    ) u_chg_cycle_ctrl (
        .clk, .rst_n, .in_good, .chg_en_n, .hiz_req, .bat_ok_short, .cv_loop,
        .ichg_low, .bat_low_rch, .bat_over_reg, .limit_loops, .therm_sd, .ts_zone,
        .det_found, .phase, .det_req, .bat_sw_en, .i_half, .vreg_low, .conv_off,
        .chg_stat_n
    );

    typedef struct packed {
        logic [3:0] req;
        logic       in_good, en_n, hiz, short_ok, cv, term, rch, bovp;
        logic [1:0] zone;
        logic       lim, det;
        logic [7:0] wait_n;
        logic [2:0] ph;
        logic       stat_n, sw, ihalf, vlow, conv;
    } row_t;

    localparam int NROWS = 13;
    localparam row_t ROWS [NROWS] = '{
        // R2 power-on start into conditioning
        '{4'd2, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b0,1'b0, 8'd4,  3'd1, 1'b0,1'b1,1'b0,1'b0,1'b0},
        // R3 short threshold held -> fast
        '{4'd3, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b0,1'b0, 8'd12, 3'd2, 1'b0,1'b1,1'b0,1'b0,1'b0},
        // R10 warm zone lowers regulation
        '{4'd10,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2, 1'b0,1'b0, 8'd3,  3'd2, 1'b0,1'b1,1'b0,1'b1,1'b0},
        // R10 cool zone halves current
        '{4'd10,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1, 1'b0,1'b0, 8'd3,  3'd2, 1'b0,1'b1,1'b1,1'b0,1'b0},
        // R10 hot/cold suspends
        '{4'd10,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd3, 1'b0,1'b0, 8'd3,  3'd2, 1'b0,1'b0,1'b0,1'b0,1'b0},
        // R4 voltage loop -> taper
        '{4'd4, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 2'd0, 1'b1,1'b0, 8'd3,  3'd3, 1'b0,1'b1,1'b0,1'b0,1'b0},
        // R4 termination -> detection
        '{4'd4, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 2'd0, 1'b0,1'b0, 8'd12, 3'd4, 1'b1,1'b0,1'b0,1'b0,1'b0},
        // R5 battery found -> done
        '{4'd5, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 2'd0, 1'b0,1'b1, 8'd2,  3'd5, 1'b1,1'b0,1'b0,1'b0,1'b0},
        // R5 recharge keeps status released
        '{4'd5, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 2'd0, 1'b0,1'b0, 8'd12, 3'd1, 1'b1,1'b1,1'b0,1'b0,1'b0},
        // R2 disable -> idle
        '{4'd2, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b0,1'b0, 8'd3,  3'd0, 1'b1,1'b0,1'b0,1'b0,1'b0},
        // R2 enable toggle starts a cycle
        '{4'd2, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b0,1'b0, 8'd3,  3'd1, 1'b0,1'b1,1'b0,1'b0,1'b0},
        // R11 over-voltage holds converter off
        '{4'd11,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 2'd0, 1'b0,1'b0, 8'd3,  3'd1, 1'b0,1'b0,1'b0,1'b0,1'b1},
        // R11 release after relaxation
        '{4'd11,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b0,1'b0, 8'd3,  3'd1, 1'b0,1'b1,1'b0,1'b0,1'b0}
    };

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_main(input string tag, input int ph, input int st, input int sw);
        chk(tag, "phase", int'(phase), ph);
        chk(tag, "chg_stat_n", int'(chg_stat_n), st);
        chk(tag, "bat_sw_en", int'(bat_sw_en), sw);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet_inputs();
        bat_ok_short = 1'b0; cv_loop = 1'b0; ichg_low = 1'b0; bat_low_rch = 1'b0;
        bat_over_reg = 1'b0; therm_sd = 1'b0; det_found = 1'b0;
        limit_loops = 3'b000; ts_zone = 2'd0; hiz_req = 1'b0; in_good = 1'b1;
    endtask

    task automatic restart();
        chg_en_n = 1'b1;
        cyc(2);
        chg_en_n = 1'b0;
        cyc(2);
    endtask

    initial begin
        // R1 reset state
        cyc(3);
        chk_main("R1", 0, 1, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NROWS; i++) begin
            in_good      = ROWS[i].in_good;
            chg_en_n     = ROWS[i].en_n;
            hiz_req      = ROWS[i].hiz;
            bat_ok_short = ROWS[i].short_ok;
            cv_loop      = ROWS[i].cv;
            ichg_low     = ROWS[i].term;
            bat_low_rch  = ROWS[i].rch;
            bat_over_reg = ROWS[i].bovp;
            ts_zone      = ROWS[i].zone;
            limit_loops  = {1'b0, ROWS[i].lim, 1'b0};
            det_found    = ROWS[i].det;
            cyc(int'(ROWS[i].wait_n));
            chk_main($sformatf("R%0d row%0d", ROWS[i].req, i), int'(ROWS[i].ph),
                     int'(ROWS[i].stat_n), int'(ROWS[i].sw));
            chk($sformatf("R%0d row%0d", ROWS[i].req, i), "i_half", int'(i_half), int'(ROWS[i].ihalf));
            chk($sformatf("R%0d row%0d", ROWS[i].req, i), "vreg_low", int'(vreg_low), int'(ROWS[i].vlow));
            chk($sformatf("R%0d row%0d", ROWS[i].req, i), "conv_off", int'(conv_off), int'(ROWS[i].conv));
            if (ROWS[i].ph == 3'd4) chk("R4", "det_req", int'(det_req), 1);
        end

        // R3 hold length boundary and restart after a gap
        quiet_inputs();
        restart();
        bat_ok_short = 1'b1;
        cyc(HOLD - 1);
        chk("R3", "phase before hold", int'(phase), 1);
        cyc(3);
        chk("R3", "phase after hold", int'(phase), 2);
        quiet_inputs();
        restart();
        bat_ok_short = 1'b1; cyc(4);
        bat_ok_short = 1'b0; cyc(1);
        bat_ok_short = 1'b1; cyc(HOLD - 1);
        chk("R3", "phase after gap", int'(phase), 1);
        cyc(3);
        chk("R3", "phase after regained hold", int'(phase), 2);

        // R6 full-rate expiry, R9 fault latch and release
        quiet_inputs();
        restart();
        cyc(65);
        chk("R6", "phase before expiry", int'(phase), 1);
        cyc(20);
        chk_main("R6", 6, 1, 0);
        bat_low_rch = 1'b1;
        cyc(12);
        chk("R9", "phase with recharge condition", int'(phase), 6);
        hiz_req = 1'b1;
        cyc(2);
        chk_main("R9", 0, 1, 0);
        bat_low_rch = 1'b0; hiz_req = 1'b0;
        cyc(2);
        chk_main("R9", 1, 0, 1);

        // R7 half-rate expiry
        limit_loops = 3'b100;
        cyc(140);
        chk("R7", "phase at half rate", int'(phase), 1);
        cyc(30);
        chk("R7", "phase after half-rate expiry", int'(phase), 6);

        // R8 thermal shutdown restarts elapsed time
        quiet_inputs();
        restart();
        cyc(60);
        therm_sd = 1'b1; cyc(1);
        therm_sd = 1'b0;
        cyc(60);
        chk("R8", "phase after timer restart", int'(phase), 1);
        cyc(30);
        chk("R8", "phase after late expiry", int'(phase), 6);

        // R4 no termination while battery below recharge threshold
        quiet_inputs();
        restart();
        bat_ok_short = 1'b1; cyc(12);
        cv_loop = 1'b1; cyc(2);
        chk("R4", "phase taper", int'(phase), 3);
        ichg_low = 1'b1; bat_low_rch = 1'b1; cyc(20);
        chk("R4", "phase held in taper", int'(phase), 3);
        bat_low_rch = 1'b0; cyc(12);
        chk_main("R4", 4, 1, 0);

        // R2 input power cycle restarts
        quiet_inputs();
        in_good = 1'b0; cyc(2);
        chk_main("R2", 0, 1, 0);
        in_good = 1'b1; cyc(2);
        chk_main("R2", 1, 0, 1);

        // R10 suspension freezes the phase
        bat_ok_short = 1'b1; ts_zone = 2'd3;
        cyc(15);
        chk_main("R10", 1, 0, 0);
        ts_zone = 2'd0; cyc(2);
        chk_main("R10", 2, 0, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1..all: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule